// File: doc/BRIEF.md
# Nibble Digit Rotate Sequencer

This block rotates three 4-bit digits around a ring made of the low digit of an 8-bit accumulator and the two digits of one memory byte. The accumulator digit, the upper memory digit and the lower memory digit move one place around that ring, clockwise or anticlockwise. The move is used for shifting packed decimal strings one digit at a time. The block owns the accumulator result register. It does the job as a single read-modify-write on a simple synchronous memory port: it reads the byte once and writes it back once.

A caller presents the byte address, the accumulator value and the direction, then pulses `start`. The controller steps through four named states. In IDLE it waits. In READ it issues the read. In WRITE it forms the new byte and stores it, and the new accumulator value is registered in the same cycle. In DONE it raises `done` for one cycle. The transitions are IDLE→READ on an accepted start, READ→WRITE always, WRITE→DONE always and DONE→IDLE always. The upper accumulator digit passes through unchanged. The block produces no status flags.

Top module: `nibble_rotate_seq`

## Requirements
- R1: With `dir_left`=0, the low digit of `acc_out` (bits 3:0) after the operation equals bits 3:0 of the byte that was read.
- R2: With `dir_left`=0, the byte written back has bits 7:4 equal to the old accumulator bits 3:0, and bits 3:0 equal to the old memory bits 7:4.
- R3: With `dir_left`=1, the low digit of `acc_out` after the operation equals bits 7:4 of the byte that was read.
- R4: With `dir_left`=1, the byte written back has bits 3:0 equal to the old accumulator bits 3:0, and bits 7:4 equal to the old memory bits 3:0.
- R5: Bits 7:4 of `acc_out` after an operation equal bits 7:4 of `acc_in` as sampled with the accepted start.
- R6: An accepted start gives `mem_re` high in the next cycle, `mem_we` high in the cycle after that, and `done` in the cycle after the write. Each operation makes exactly one read and one write, both at the address sampled with start.
- R7: A `start` that arrives while `busy` is high has no effect: it causes no further read or write, and no other memory byte is touched.
- R8: `done` is high for exactly one cycle per operation. `busy` is high from the READ cycle through the DONE cycle.
- R9: After reset `busy`, `done`, `mem_re` and `mem_we` are low and `acc_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only in IDLE |
| dir_left | input | 1 | 0 = right rotate, 1 = left rotate; sampled with start |
| addr_in | input | ADDR_W | Byte address, sampled with start |
| acc_in | input | 2*NIB_W | Accumulator value, sampled with start |
| acc_out | output | 2*NIB_W | Registered accumulator result, updated with the write |
| busy | output | 1 | High in READ, WRITE and DONE |
| done | output | 1 | One-cycle completion strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_re | output | 1 | Read enable; data returns the following cycle |
| mem_rdata | input | 2*NIB_W | Read data, valid one cycle after `mem_re` |
| mem_we | output | 1 | Write enable |
| mem_wdata | output | 2*NIB_W | Write data |

## Verification
The properties assume a memory that returns the addressed byte exactly one cycle after `mem_re`, and that nothing else writes that byte between the read and the write. They also assume `acc_in` and `dir_left` matter only in the cycle that start is accepted. The bench memory model is a synchronous-read array that only the block writes during an operation, apart from preloads done while the block is idle. Start is driven only at chosen points: once while idle, and deliberately while busy.

// File: rtl/nds_pkg.sv
package nds_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } nds_state_e;
endpackage

// File: rtl/nds_fsm.sv
module nds_fsm
    import nds_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output nds_state_e state,
    output logic       accept,
    output logic       rd_en,
    output logic       wr_en,
    output logic       busy,
    output logic       done
);
    nds_state_e state_q;
    nds_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_READ;
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        accept = 1'b0;
        rd_en  = 1'b0;
        wr_en  = 1'b0;
        busy   = 1'b1;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            ST_READ:  rd_en = 1'b1;
            ST_WRITE: wr_en = 1'b1;
            ST_DONE:  done  = 1'b1;
            default:  busy  = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/nds_rotate.sv
module nds_rotate #(
    parameter int NIB_W = 4
) (
    input  logic                 left,
    input  logic [NIB_W-1:0]     acc_lo,
    input  logic [2*NIB_W-1:0]   mem_byte,
    output logic [NIB_W-1:0]     acc_lo_new,
    output logic [2*NIB_W-1:0]   mem_byte_new
);
    localparam int BYTE_W = 2 * NIB_W;

    logic [NIB_W-1:0] m_hi;
    logic [NIB_W-1:0] m_lo;
    logic [BYTE_W-1:0] rot_r;
    logic [BYTE_W-1:0] rot_l;

    assign m_hi = mem_byte[BYTE_W-1:NIB_W];
    assign m_lo = mem_byte[NIB_W-1:0];

    // right: acc->mem hi, mem hi->mem lo, mem lo->acc
    assign rot_r = {acc_lo, m_hi};
    // left: acc->mem lo, mem lo->mem hi, mem hi->acc
    assign rot_l = {m_lo, acc_lo};

    always_comb begin
        if (left) begin
            acc_lo_new   = m_hi;
            mem_byte_new = rot_l;
        end else begin
            acc_lo_new   = m_lo;
            mem_byte_new = rot_r;
        end
    end
endmodule

// File: rtl/nds_regs.sv
module nds_regs #(
    parameter int NIB_W  = 4,
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic                 wr_en,
    input  logic                 dir_in,
    input  logic [ADDR_W-1:0]    addr_in,
    input  logic [2*NIB_W-1:0]   acc_in,
    input  logic [NIB_W-1:0]     acc_lo_new,
    output logic                 dir_q,
    output logic [ADDR_W-1:0]    addr_q,
    output logic [NIB_W-1:0]     acc_lo_q,
    output logic [2*NIB_W-1:0]   acc_out
);
    localparam int BYTE_W = 2 * NIB_W;

    logic [NIB_W-1:0] acc_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q    <= 1'b0;
            addr_q   <= '0;
            acc_lo_q <= '0;
            acc_hi_q <= '0;
        end else if (accept) begin
            dir_q    <= dir_in;
            addr_q   <= addr_in;
            acc_lo_q <= acc_in[NIB_W-1:0];
            acc_hi_q <= acc_in[BYTE_W-1:NIB_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     acc_out <= '0;
        else if (wr_en) acc_out <= {acc_hi_q, acc_lo_new};
    end
endmodule

// File: rtl/nibble_rotate_seq.sv
module nibble_rotate_seq
    import nds_pkg::*;
#(
    parameter int NIB_W  = 4,
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 dir_left,
    input  logic [ADDR_W-1:0]    addr_in,
    input  logic [2*NIB_W-1:0]   acc_in,
    output logic [2*NIB_W-1:0]   acc_out,
    output logic                 busy,
    output logic                 done,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_re,
    input  logic [2*NIB_W-1:0]   mem_rdata,
    output logic                 mem_we,
    output logic [2*NIB_W-1:0]   mem_wdata
);
    nds_state_e        state;
    logic              accept;
    logic              rd_en;
    logic              wr_en;
    logic              dir_q;
    logic [NIB_W-1:0]  acc_lo_q;
    logic [NIB_W-1:0]  acc_lo_new;

    nds_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .state  (state),
        .accept (accept),
        .rd_en  (rd_en),
        .wr_en  (wr_en),
        .busy   (busy),
        .done   (done)
    );

    nds_regs #(.NIB_W(NIB_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .wr_en      (wr_en),
        .dir_in     (dir_left),
        .addr_in    (addr_in),
        .acc_in     (acc_in),
        .acc_lo_new (acc_lo_new),
        .dir_q      (dir_q),
        .addr_q     (mem_addr),
        .acc_lo_q   (acc_lo_q),
        .acc_out    (acc_out)
    );

    nds_rotate #(.NIB_W(NIB_W)) u_rot (
        .left         (dir_q),
        .acc_lo       (acc_lo_q),
        .mem_byte     (mem_rdata),
        .acc_lo_new   (acc_lo_new),
        .mem_byte_new (mem_wdata)
    );

    assign mem_re = rd_en;
    assign mem_we = wr_en;

    logic unused_state;
    assign unused_state = ^state;
endmodule

// File: rtl/nibble_rotate_seq_chk.sv
module nibble_rotate_seq_chk #(
    parameter int NIB_W  = 4,
    parameter int ADDR_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 dir_left,
    input logic [ADDR_W-1:0]    addr_in,
    input logic [2*NIB_W-1:0]   acc_in,
    input logic [2*NIB_W-1:0]   acc_out,
    input logic                 busy,
    input logic                 done,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic                 mem_re,
    input logic [2*NIB_W-1:0]   mem_rdata,
    input logic                 mem_we,
    input logic [2*NIB_W-1:0]   mem_wdata
);
    localparam int BYTE_W = 2 * NIB_W;

    logic              c_dir;
    logic [NIB_W-1:0]  c_lo;
    logic [NIB_W-1:0]  c_hi;
    logic [ADDR_W-1:0] c_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_dir  <= 1'b0;
            c_lo   <= '0;
            c_hi   <= '0;
            c_addr <= '0;
        end else if (start && !busy) begin
            c_dir  <= dir_left;
            c_lo   <= acc_in[NIB_W-1:0];
            c_hi   <= acc_in[BYTE_W-1:NIB_W];
            c_addr <= addr_in;
        end
    end

    p_right_acc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !c_dir) |=> acc_out[NIB_W-1:0] == $past(mem_rdata[NIB_W-1:0]));
    p_right_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !c_dir) |-> mem_wdata == {c_lo, mem_rdata[BYTE_W-1:NIB_W]});
    p_left_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && c_dir) |=> acc_out[NIB_W-1:0] == $past(mem_rdata[BYTE_W-1:NIB_W]));
    p_left_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && c_dir) |-> mem_wdata == {mem_rdata[NIB_W-1:0], c_lo});
    p_acc_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> acc_out[BYTE_W-1:NIB_W] == c_hi);
    p_read_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> mem_re);
    p_write_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (mem_we && !mem_re));
    p_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we) |-> mem_addr == c_addr);
    p_done_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> done);
    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !mem_re);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_busy_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we || done) |-> busy);

    logic unused_chk;
    assign unused_chk = ^mem_addr;
endmodule

bind nibble_rotate_seq nibble_rotate_seq_chk #(.NIB_W(NIB_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/nibble_rotate_seq_test.sv
module nibble_rotate_seq_test;
    localparam int NW = 4;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic dir_left = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] acc_out;
    logic busy, done, mem_re, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_rdata, mem_wdata;

    logic [7:0] mem [0:(1<<AW)-1];
    logic ld = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    int writes = 0;
    int reads = 0;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    nibble_rotate_seq #(.NIB_W(NW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_left(dir_left),
        .addr_in(addr_in), .acc_in(acc_in), .acc_out(acc_out),
        .busy(busy), .done(done), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    always @(posedge clk) begin
        if (ld) mem[ld_addr] <= ld_data;
        if (mem_re) begin
            mem_rdata <= mem[mem_addr];
            reads <= reads + 1;
        end
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            writes <= writes + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ld = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld = 1'b0;
    endtask

    task automatic run_op(input logic left, input logic [AW-1:0] a,
                          input logic [7:0] acc, input logic [7:0] m, input bit full);
        logic [7:0] exp_acc, exp_mem;
        int w0, r0;
        if (left) begin
            exp_acc = {acc[7:4], m[7:4]};
            exp_mem = {m[3:0], acc[3:0]};
        end else begin
            exp_acc = {acc[7:4], m[3:0]};
            exp_mem = {acc[3:0], m[7:4]};
        end
        preload(a, m);
        w0 = writes; r0 = reads;
        start = 1'b1; dir_left = left; addr_in = a; acc_in = acc;
        @(negedge clk);
        start = 1'b0; dir_left = ~left; acc_in = ~acc; addr_in = ~a;
        if (full) begin
            chk("R6 read", mem_re, 1);
            chk("R8 busy", busy, 1);
        end
        @(negedge clk);
        if (full) chk("R6 write", mem_we, 1);
        @(negedge clk);
        if (full) chk("R8 done", done, 1);
        if (left) begin
            chk("R3 acc lo", acc_out[3:0], exp_acc[3:0]);
            chk("R4 mem", mem[a], exp_mem);
        end else begin
            chk("R1 acc lo", acc_out[3:0], exp_acc[3:0]);
            chk("R2 mem", mem[a], exp_mem);
        end
        chk("R5 acc hi", acc_out[7:4], exp_acc[7:4]);
        @(negedge clk);
        if (full) begin
            chk("R8 done drop", done, 0);
            chk("R6 one write", writes - w0, 1);
            chk("R6 one read", reads - r0, 1);
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 busy", busy, 0);
        chk("R9 done", done, 0);
        chk("R9 re", mem_re, 0);
        chk("R9 we", mem_we, 0);
        chk("R9 acc", acc_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // exhaustive sweep of acc low digit, memory byte, direction
        for (int d = 0; d < 2; d++)
            for (int a = 0; a < 16; a++)
                for (int m = 0; m < 256; m++)
                    run_op(d[0], AW'((m ^ (a << 4)) + d), 8'(((a * 5 + m) % 16) << 4 | a),
                           8'(m), (m % 37) == 0);

        // R7: start held while busy must not restart or touch another byte
        begin
            int w0, r0;
            preload(8'h21, 8'h3C);
            preload(8'h42, 8'h96);
            w0 = writes; r0 = reads;
            start = 1'b1; dir_left = 1'b0; addr_in = 8'h21; acc_in = 8'hA5;
            @(negedge clk);
            addr_in = 8'h42; dir_left = 1'b1; acc_in = 8'h0F;
            @(negedge clk);
            @(negedge clk);
            chk("R7 done", done, 1);
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            chk("R7 writes", writes - w0, 1);
            chk("R7 reads", reads - r0, 1);
            chk("R7 other byte", mem[8'h42], 8'h96);
            chk("R7 target", mem[8'h21], 8'h53);
            chk("R7 acc", acc_out, 8'hAC);
            chk("R7 idle", busy, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule